// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources and presents one interrupt line to the processor. Each source owns an 8-bit control register that holds a pending flag and a 3-bit priority level. Level 7 parks a source as disabled. A parameter mask chooses, for each source, one of two kinds of request input. An edge-type source latches a rising request into its pending flag. A level-type source's flag simply mirrors its request input.

Software reaches the block through a byte-wide register port with an address, a write strobe and a read strobe. Read data is combinational for the addressed register. Reading the vector register does three things: it returns the index of the winning source, it acknowledges that source, and it loads the winner's level into a current-mask register. The processor line is raised only while the winner's level is strictly below that mask.

Address map: control registers sit at addresses 0 to N_SRC-1. The vector register is at N_SRC and is read-only. The mask register is at N_SRC+1.

Top module: `irq_ctrl_top`

## Requirements
- R1: A control register reads as {3'b000, pending, 1'b0, level[2:0]}: the pending flag is bit 4 and the level is bits 2:0. Writes to bits 7:5 and bit 3 are ignored, and those bits read 0. A write always loads the level field.
- R2: After reset every control register reads 0x07, the mask register reads 0x07, the vector register reads 0xFF and irq_o is 0.
- R3: For an edge-type source, a 0-to-1 transition of its request input (through a 2-stage synchronizer) sets the pending flag. The flag is visible on the third rising clock edge after the input rises and stays set after the input falls.
- R4: For an edge-type source, a control-register write with bit 4 = 1 sets the pending flag, and a write with bit 4 = 0 clears it.
- R5: For a level-type source, the pending flag follows the synchronized request input, and writes to bit 4 have no effect on it.
- R6: When a software clear of an edge-type pending flag lands on the same clock edge as a newly detected rising request, the flag ends cleared.
- R7: A vector read clears the winning edge-type source's pending flag. If this lands on the same edge as a new rising request on that source, the flag ends cleared.
- R8: A vector read does not clear a level-type source's pending flag.
- R9: The winner is the pending source with the lowest level value, with ties going to the lower index. A source at level 7 never wins.
- R10: irq_o is 1 exactly when a winner exists and its level is strictly below the mask register value.
- R11: A vector read returns the winner's index, or 0xFF when there is no winner. It loads the winner's level into the mask register and leaves the mask unchanged when there is no winner. The mask register is readable and writable in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Peripheral request inputs, asynchronous |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; side effects apply only at the vector address |
| rdata_o | output | 8 | Read data of the addressed register, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A stuck or stale pending flag shows up in two ways: at the control-register read in the very next cycle, and on irq_o in that same cycle, because both the arbiter and the line are combinational from the flags. A lost acknowledge or a wrong race priority leaves a flag set that the next vector read returns a second time. A wrong winner choice or a wrong mask load shows at once in the vector value and on irq_o. The race cases are aimed at exactly the clock edge where the synchronized rising edge is detected.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W     = 3;
  localparam int PEND_BIT  = 4;
  localparam int SYNC_N    = 2;
  localparam logic [7:0] NONE_CODE = 8'hFF;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = 3'd7;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
#(
  parameter bit EDGE = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       ack_i,
  output logic       pend_o,
  output lvl_t       lvl_o
);
  logic [SYNC_N-1:0] sync_q;
  logic req_s, req_d_q, pend_q;
  lvl_t lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      req_d_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_N-2:0], req_i};
      req_d_q <= req_s;
    end
  end
  assign req_s = sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lvl_q <= LVL_OFF;
    else if (wr_i) lvl_q <= wdata_i[LVL_W-1:0];
  end

  generate
    if (EDGE) begin : g_edge
      logic rise, clr, set;
      assign rise = req_s & ~req_d_q;
      assign clr  = (wr_i & ~wdata_i[PEND_BIT]) | ack_i;
      assign set  = (wr_i &  wdata_i[PEND_BIT]) | rise;
      // clear dominates any same-cycle set
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  pend_q <= 1'b0;
        else if (clr) pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
      end

      a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr |=> !pend_o);
      a_r3_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && !clr) |=> pend_o);
    end else begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= req_s;
      end

      a_r5_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && req_s) |=> pend_o);
      a_r8_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && req_s) |=> pend_o);
    end
  endgenerate

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            pend_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        valid_o,
  output logic [IDX_W-1:0]            idx_o,
  output lvl_t                        lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_OFF;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lower index on ties
      if (pend_i[i] && lvl_i[i] != LVL_OFF && (!valid_o || lvl_i[i] < lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int                N_SRC     = 8,
  parameter logic [N_SRC-1:0]  EDGE_MASK = N_SRC'('h0F),
  parameter int                ADDR_W    = $clog2(N_SRC + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [ADDR_W-1:0] VEC_ADDR  = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_SRC + 1);

  logic [N_SRC-1:0]            pend, wr_sel, ack;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        win_valid, vec_rd;
  logic [IDX_W-1:0]            win_idx;
  lvl_t                        win_lvl, mask_q;

  assign vec_rd = rd_en_i && addr_i == VEC_ADDR;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign wr_sel[i] = wr_en_i && addr_i == ADDR_W'(i);
      assign ack[i]    = vec_rd && win_valid && win_idx == IDX_W'(i);
      irq_src_cell #(.EDGE(EDGE_MASK[i])) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i[i]),
        .wr_i   (wr_sel[i]),
        .wdata_i(wdata_i),
        .ack_i  (ack[i]),
        .pend_o (pend[i]),
        .lvl_o  (lvl[i])
      );

      a_r9_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_valid && pend[i] && lvl[i] != LVL_OFF) |->
          (lvl[i] > win_lvl || (lvl[i] == win_lvl && IDX_W'(i) >= win_idx)));
    end
  endgenerate

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i (pend),
    .lvl_i  (lvl),
    .valid_o(win_valid),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mask_q <= LVL_OFF;
    else if (vec_rd && win_valid)            mask_q <= win_lvl;
    else if (wr_en_i && addr_i == MASK_ADDR) mask_q <= wdata_i[LVL_W-1:0];
  end

  assign irq_o = win_valid && (win_lvl < mask_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(N_SRC)) begin
      rdata_o[PEND_BIT]    = pend[addr_i[IDX_W-1:0]];
      rdata_o[LVL_W-1:0]   = lvl[addr_i[IDX_W-1:0]];
    end else if (addr_i == VEC_ADDR) begin
      rdata_o = win_valid ? 8'(win_idx) : NONE_CODE;
    end else if (addr_i == MASK_ADDR) begin
      rdata_o[LVL_W-1:0] = mask_q;
    end
  end

  a_r11_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && win_valid) |=> mask_q == $past(win_lvl));
  a_r11_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && !win_valid) |=> $stable(mask_q));
  a_r10_no_disabled_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_lvl != LVL_OFF && pend[win_idx]));
  a_r7_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack));
endmodule

// File: tb/tb_irq_ctrl_top.sv
module tb_irq_ctrl_top;
  localparam int N = 8;
  localparam logic [3:0] VEC = 4'd8;
  localparam logic [3:0] MSK = 4'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_top #(.N_SRC(N), .EDGE_MASK(8'h0F)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int i = 0; i < N; i++) begin
      peek(4'(i), d); chk("R2 ctrl reset", d, 8'h07);
    end
    peek(MSK, d); chk("R2 mask reset", d, 8'h07);
    peek(VEC, d); chk("R2 vector none", d, 8'hFF);
    chk("R2 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    do_reset();
    wr(4'd2, 8'hFF); peek(4'd2, d); chk("R1 layout all ones", d, 8'h17);
    wr(4'd2, 8'hEA); peek(4'd2, d); chk("R1 layout mixed", d, 8'h02);
    wr(VEC, 8'h33);  peek(MSK, d);  chk("R1 vector write ignored", d, 8'h07);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    do_reset();
    wr(4'd1, 8'h03);
    req[1] = 1'b1; repeat (3) @(negedge clk);
    req[1] = 1'b0; repeat (3) @(negedge clk);
    peek(4'd1, d); chk("R3 edge latched", d, 8'h13);
    chk("R10 irq level3<7", {7'd0, irq}, 8'h01);
    rd(VEC, d);    chk("R11 vector idx", d, 8'h01);
    peek(4'd1, d); chk("R7 ack clears edge", d, 8'h03);
    peek(MSK, d);  chk("R11 mask loaded", d, 8'h03);
    rd(VEC, d);    chk("R11 vector none", d, 8'hFF);
    peek(MSK, d);  chk("R11 mask held on none", d, 8'h03);
  endtask

  task automatic t_sw();
    logic [7:0] d;
    do_reset();
    wr(4'd0, 8'h14); peek(4'd0, d); chk("R4 sw set", d, 8'h14);
    chk("R10 irq after sw set", {7'd0, irq}, 8'h01);
    wr(4'd0, 8'h04); peek(4'd0, d); chk("R4 sw clear", d, 8'h04);
    chk("R10 irq after sw clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    do_reset();
    wr(4'd5, 8'h01);
    req[5] = 1'b1; repeat (4) @(negedge clk);
    peek(4'd5, d); chk("R5 level follows", d, 8'h11);
    wr(4'd5, 8'h01); peek(4'd5, d); chk("R5 sw clear ignored", d, 8'h11);
    wr(4'd6, 8'h11); peek(4'd6, d); chk("R5 sw set ignored", d, 8'h01);
    req[5] = 1'b0; repeat (4) @(negedge clk);
    peek(4'd5, d); chk("R5 level drops", d, 8'h01);
  endtask

  task automatic t_race_sw();
    logic [7:0] d;
    do_reset();
    wr(4'd0, 8'h12);
    req[0] = 1'b1; repeat (2) @(negedge clk);
    wr(4'd0, 8'h02);  // lands on the rise-detect edge
    repeat (2) @(negedge clk);
    peek(4'd0, d); chk("R6 sw clear beats rise", d, 8'h02);
    req[0] = 1'b0; @(negedge clk);
  endtask

  task automatic t_race_ack();
    logic [7:0] d;
    do_reset();
    wr(4'd0, 8'h12);
    req[0] = 1'b1; repeat (2) @(negedge clk);
    rd(VEC, d); chk("R7 race vector idx", d, 8'h00);
    repeat (2) @(negedge clk);
    peek(4'd0, d); chk("R7 ack beats rise", d, 8'h02);
    req[0] = 1'b0; @(negedge clk);
  endtask

  task automatic t_level_ack();
    logic [7:0] d;
    do_reset();
    wr(4'd4, 8'h03);
    req[4] = 1'b1; repeat (4) @(negedge clk);
    rd(VEC, d);    chk("R8 vector idx", d, 8'h04);
    peek(4'd4, d); chk("R8 level kept", d, 8'h13);
    chk("R10 irq masked equal", {7'd0, irq}, 8'h00);
    req[4] = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    do_reset();
    wr(4'd0, 8'h15); wr(4'd2, 8'h12); wr(4'd3, 8'h12); wr(4'd1, 8'h17);
    rd(VEC, d); chk("R9 lowest first", d, 8'h02);
    peek(MSK, d); chk("R11 mask lvl2", d, 8'h02);
    rd(VEC, d); chk("R9 tie next", d, 8'h03);
    rd(VEC, d); chk("R9 then level5", d, 8'h00);
    rd(VEC, d); chk("R9 disabled skipped", d, 8'hFF);
    peek(MSK, d); chk("R11 mask after none", d, 8'h05);
    peek(4'd1, d); chk("R9 disabled still pending", d, 8'h17);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    do_reset();
    wr(4'd0, 8'h13);
    wr(MSK, 8'hF3); peek(MSK, d); chk("R11 mask rw", d, 8'h03);
    chk("R10 equal masked", {7'd0, irq}, 8'h00);
    wr(MSK, 8'h04);
    chk("R10 below mask", {7'd0, irq}, 8'h01);
    wr(4'd0, 8'h17);
    chk("R10 level7 no irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_edge();
    t_sw();
    t_level();
    t_race_sw();
    t_race_ack();
    t_level_ack();
    t_prio();
    t_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule